// File: doc/BRIEF.md
# QoS Priority SRAM Port Arbiter

This block sits in front of a single-ported SRAM and chooses, every cycle, which of several masters gets the port. Each master presents a request with an address, write data and a write flag. The arbiter raises that master's ready in the same cycle it wins, and it routes the winner's fields to the SRAM pins. A read is answered one cycle later with a per-port response strobe and the shared read-data bus.

Each port has a 2-bit service level. The meanings are: 0 = background, 1 = bandwidth-sensitive, 2 = latency-sensitive, 3 = latency-critical. The highest level present wins. Among requests at that level, the lowest port index wins. Requests at levels 0 and 1 are held back for one cycle before they may compete, so those ports always pay at least one added cycle per access. Software sets the levels through a small register file with reset defaults. One port, the trace port, is tied to level 3 and cannot be reprogrammed.

Back-pressure rules for the request side are as follows. A master raises valid and holds valid, address, data and write flag unchanged until it sees ready high in the same cycle. Ready is a combinational function of all valids and of the current levels. A master that loses keeps its request up and is arbitrated again in the next cycle. Starvation of low-level ports is allowed by design.

Top module: `qos_sram_arbiter`

## Requirements
- R1: When eligible requests carry different levels (0 background, 1 bandwidth-sensitive, 2 latency-sensitive, 3 latency-critical), the grant goes to a request at the highest level present.
- R2: Among eligible requests at the same highest level, the grant goes to the one with the lowest port index.
- R3: A request at level 0 or 1 cannot be granted in the first cycle it is raised. It becomes eligible from its second consecutive cycle of being held while not granted. A request at level 2 or 3 is eligible in its first cycle.
- R4: At most one ready bit is high per cycle, ready is high only for a port whose valid is high, and a losing request that stays asserted is arbitrated again in the next cycle.
- R5: In a cycle with a grant, mem_en is 1 and mem_addr, mem_wdata and mem_we carry the granted port's fields. In a cycle without a grant, mem_en is 0.
- R6: A granted read (write flag 0) raises rsp_valid for that port alone in the next cycle, with rsp_rdata equal to mem_rdata. A granted write raises no rsp_valid.
- R7: After reset the levels are port 0 = 3, port 1 = 2, port 2 = 2, port 3 = 3, and port 4 = 3. No ready or rsp_valid is high.
- R8: Port 4 (the trace port) always has level 3. A full-word write to its register has no effect, and reads of it return 3.
- R9: A configuration write takes effect only when cfg_be is 4'hF. The level is then taken from cfg_wdata[1:0] of the selected port. A write with any other byte-enable pattern leaves every level unchanged.
- R10: cfg_rdata returns the selected port's level zero-extended to 32 bits, with bits [31:2] equal to 0. A selection at or above the port count reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 5 | Per-port request valid |
| req_ready | output | 5 | Per-port grant, one-hot or zero |
| req_we | input | 5 | Per-port write flag |
| req_addr | input | 40 | Per-port address, port p in bits [8p+7:8p] |
| req_wdata | input | 80 | Per-port write data, port p in bits [16p+15:16p] |
| rsp_valid | output | 5 | Per-port read-data valid, one cycle after a read grant |
| rsp_rdata | output | 16 | Shared read data |
| mem_en | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 8 | SRAM address |
| mem_wdata | output | 16 | SRAM write data |
| mem_rdata | input | 16 | SRAM read data, valid the cycle after an access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select (port index) |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_sel |

## Verification
The bench builds the block with its defaults: five ports, 8-bit addresses, 16-bit data and the trace port at index 4. At that size it can visit every one of the 256 level assignments for the four programmable ports. For each assignment it applies all 31 non-empty request masks. For each mask it predicts the first-cycle winner, which comes from levels 2 and 3 only, and the second-cycle winner, which comes from the whole mask, where the penalty has expired. This reaches every level tie, every order of port indices and the one-cycle hold-back. The routing of the winner's address, data and write flag to the SRAM is checked in the same sweep. Separate directed writes cover the byte-enable filter, the fixed trace level, zero-extended readback and out-of-range selects.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  typedef logic [1:0] qos_t;

  localparam qos_t QOS_BACKGROUND = 2'd0;
  localparam qos_t QOS_BANDWIDTH  = 2'd1;
  localparam qos_t QOS_LATENCY    = 2'd2;
  localparam qos_t QOS_CRITICAL   = 2'd3;

  // Levels below this threshold wait one cycle before competing.
  localparam qos_t QOS_FAST_MIN   = QOS_LATENCY;

  localparam logic [3:0] CFG_FULL_WORD = 4'hF;
endpackage

// File: rtl/qos_cfg_regs.sv
module qos_cfg_regs
  import qos_arb_pkg::*;
#(
  parameter int N        = 5,
  parameter int TRACE_ID = 4,
  parameter logic [2*N-1:0] QOS_RESET = '1,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [SW-1:0]        cfg_sel,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  output qos_t [N-1:0]         lvl_o
);

  logic full_wr;
  assign full_wr = cfg_we && (cfg_be == CFG_FULL_WORD);

  for (genvar p = 0; p < N; p++) begin : g_port
    if (p == TRACE_ID) begin : g_fixed
      assign lvl_o[p] = QOS_CRITICAL;
    end else begin : g_prog
      qos_t lvl_q;
      always_ff @(posedge clk) begin
        if (!rst_n)
          lvl_q <= QOS_RESET[2*p +: 2];
        else if (full_wr && cfg_sel == SW'(p))
          lvl_q <= cfg_wdata[1:0];
      end
      assign lvl_o[p] = lvl_q;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (int'(cfg_sel) < N)
      cfg_rdata[1:0] = lvl_o[cfg_sel];
  end

  // R9: partial-word writes leave every level untouched
  p_partial_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_be != CFG_FULL_WORD) |=> $stable(lvl_o));

  // R8: trace port level never moves off the top level
  p_trace_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (lvl_o[TRACE_ID] == QOS_CRITICAL) && $stable(lvl_o[TRACE_ID]));

endmodule

// File: rtl/qos_elig.sv
module qos_elig
  import qos_arb_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] gnt,
  input  qos_t [N-1:0] lvl,
  output logic [N-1:0] elig
);

  logic [N-1:0] waited_q;

  always_ff @(posedge clk) begin
    if (!rst_n) waited_q <= '0;
    else        waited_q <= req & ~gnt;
  end

  for (genvar i = 0; i < N; i++) begin : g_el
    assign elig[i] = req[i] && ((lvl[i] >= QOS_FAST_MIN) || waited_q[i]);

    // R3: a slow-level grant needs a request held from the previous cycle
    p_slow_waits_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[i] && lvl[i] < QOS_FAST_MIN) |-> $past(req[i]));
  end

endmodule

// File: rtl/qos_pick.sv
module qos_pick
  import qos_arb_pkg::*;
#(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] elig,
  input  qos_t [N-1:0] lvl,
  output logic [N-1:0] gnt
);

  qos_t best;
  logic any;
  int   win;

  always_comb begin
    best = QOS_BACKGROUND;
    any  = 1'b0;
    win  = 0;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lowest index on a tie
      if (elig[i] && (!any || lvl[i] > best)) begin
        best = lvl[i];
        any  = 1'b1;
        win  = i;
      end
    end
    gnt = '0;
    if (any) gnt[win] = 1'b1;
  end

  // R4: never more than one grant
  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R4: a grant always lands on an eligible request
  p_gnt_eligible_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~elig) == '0);

  // R4: any eligible request yields a grant
  p_no_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (elig != '0) |-> (gnt != '0));

endmodule

// File: rtl/qos_sram_arbiter.sv
module qos_sram_arbiter
  import qos_arb_pkg::*;
#(
  parameter int N        = 5,
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int TRACE_ID = 4,
  parameter logic [2*N-1:0] QOS_RESET = 10'b11_11_10_10_11,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  output logic [N-1:0]    req_ready,
  input  logic [N-1:0]    req_we,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*DW-1:0] req_wdata,
  output logic [N-1:0]    rsp_valid,
  output logic [DW-1:0]   rsp_rdata,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            cfg_we,
  input  logic [SW-1:0]   cfg_sel,
  input  logic [3:0]      cfg_be,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata
);

  qos_t [N-1:0] lvl;
  logic [N-1:0] elig;
  logic [N-1:0] gnt;

  qos_cfg_regs #(.N(N), .TRACE_ID(TRACE_ID), .QOS_RESET(QOS_RESET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lvl_o(lvl)
  );

  qos_elig #(.N(N)) u_elig (
    .clk(clk), .rst_n(rst_n), .req(req_valid), .gnt(gnt), .lvl(lvl), .elig(elig)
  );

  qos_pick #(.N(N)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .lvl(lvl), .gnt(gnt)
  );

  assign req_ready = gnt;

  always_comb begin
    mem_en    = |gnt;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) begin
        mem_we    = req_we[i];
        mem_addr  = req_addr[i*AW +: AW];
        mem_wdata = req_wdata[i*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_valid <= '0;
    else        rsp_valid <= gnt & ~req_we;
  end

  assign rsp_rdata = mem_rdata;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6: a response follows only a read grant one cycle earlier
    p_rsp_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[i] |-> $past(req_ready[i] && !req_we[i]));

    // R4: ready only toward a requesting port
    p_ready_needs_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready[i] |-> req_valid[i]);
  end

  // R5: the SRAM strobe mirrors the presence of a grant
  p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en == (req_ready != '0));

endmodule

// File: tb/qos_sram_arbiter_tb.sv
module qos_sram_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 5;
  localparam int AW = 8;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    req_valid;
  logic [N-1:0]    req_ready;
  logic [N-1:0]    req_we;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_wdata;
  logic [N-1:0]    rsp_valid;
  logic [DW-1:0]   rsp_rdata;
  logic            mem_en, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata, mem_rdata;
  logic            cfg_we;
  logic [2:0]      cfg_sel;
  logic [3:0]      cfg_be;
  logic [31:0]     cfg_wdata, cfg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  int lv [N];

  qos_sram_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected under 150000", cycles);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // winner: highest level, then lowest index; fast_only keeps levels 2 and 3
  function automatic int winner(logic [N-1:0] m, bit fast_only);
    int w = -1;
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && (!fast_only || lv[i] >= 2) && lv[i] > best) begin
        best = lv[i];
        w = i;
      end
    return w;
  endfunction

  function automatic logic [N-1:0] oh(int w);
    logic [N-1:0] r = '0;
    if (w >= 0) r[w] = 1'b1;
    return r;
  endfunction

  task automatic cfg_write(int sel, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(sel); cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(int sel, output logic [31:0] d);
    cfg_sel = 3'(sel);
    #1 d = cfg_rdata;
  endtask

  task automatic check_grant(string req, int w);
    check(req, 32'(req_ready), 32'(oh(w)));
    check({req, " R5 en"}, 32'(mem_en), 32'(w >= 0));
    if (w >= 0) begin
      check({req, " R5 addr"}, 32'(mem_addr), 32'(req_addr[w*AW +: AW]));
      check({req, " R5 data"}, 32'(mem_wdata), 32'(req_wdata[w*DW +: DW]));
      check({req, " R5 we"}, 32'(mem_we), 32'(req_we[w]));
    end
  endtask

  task automatic check_rsp(int w);
    logic [N-1:0] e = '0;
    if (w >= 0 && !req_we[w]) e = oh(w);
    check("R6 rsp_valid", 32'(rsp_valid), 32'(e));
    if (e != '0) check("R6 rsp_rdata", 32'(rsp_rdata), 32'(mem_rdata));
  endtask

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; req_valid = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_be = '0;
    cfg_wdata = '0; mem_rdata = '0;
    for (int p = 0; p < N; p++) begin
      req_we[p] = p[0];
      req_addr[p*AW +: AW] = AW'(p * 16 + 3);
      req_wdata[p*DW +: DW] = DW'(16'hA000 + p);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset state
    lv = '{3, 2, 2, 3, 3};
    for (int p = 0; p < N; p++) begin
      cfg_read(p, rd);
      check("R7 reset level", rd, 32'(lv[p]));
    end
    check("R7 ready idle", 32'(req_ready), 0);
    check("R7 rsp idle", 32'(rsp_valid), 0);

    // R9 partial writes ignored
    cfg_write(1, 4'h1, 32'h0);
    cfg_write(2, 4'h7, 32'h1);
    cfg_read(1, rd); check("R9 partial be ignored p1", rd, 32'd2);
    cfg_read(2, rd); check("R9 partial be ignored p2", rd, 32'd2);
    // R9, R10 full write and zero-extended readback
    cfg_write(0, 4'hF, 32'hFFFF_FFFE);
    cfg_read(0, rd); check("R10 zero-extended readback", rd, 32'd2);
    // R8 trace port fixed
    cfg_write(4, 4'hF, 32'h0);
    cfg_read(4, rd); check("R8 trace level fixed", rd, 32'd3);
    // R10 out-of-range select
    for (int s = N; s < 8; s++) begin
      cfg_read(s, rd); check("R10 out-of-range read", rd, 32'd0);
    end

    // sweep: all level assignments x all request masks (R1 R2 R3 R4 R5 R6)
    for (int cfg = 0; cfg < 256; cfg++) begin
      for (int p = 0; p < 4; p++) begin
        lv[p] = (cfg >> (2*p)) & 3;
        cfg_write(p, 4'hF, 32'(lv[p]) | 32'hABCD_0000);
      end
      lv[4] = 3;
      for (int m = 1; m < 32; m++) begin
        int w1, w2;
        @(negedge clk);
        req_valid = N'(m);
        mem_rdata = DW'(m * 97 + cfg);
        w1 = winner(N'(m), 1'b1);
        #1 check_grant("R3 first-cycle grant", w1);
        @(negedge clk);
        #1 check_rsp(w1);
        w2 = winner(N'(m), 1'b0);
        check_grant("R1 R2 R4 held-request grant", w2);
        @(negedge clk);
        req_valid = '0;
        #1 check_rsp(w2);
      end
    end
    summary();
  end
endmodule